// File: doc/BRIEF.md
# Crosspoint Routing Configuration Controller

This block keeps the routing state for a crosspoint switch with 32 outputs and 32 inputs. Every output either takes one chosen input or is switched off. Software or an upstream sequencer stages a new routing pattern in a holding rank. It writes that rank one entry at a time through a parallel port, writes every entry at once with a broadcast, or shifts the whole pattern in bit by bit over a serial line. A single update strobe then copies the holding rank into the live rank. The live rank drives the per-output select and enable lines, so every output switches on the same clock edge.

The serial line passes on the bit that falls off the end of the holding rank through a serial-out pin. Several controllers can therefore be chained from one data wire. A synchronous reset clears only the live rank, so all outputs go off. A staged pattern survives reset and can be applied afterwards with a single update.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: In the cycle after reset is sampled high, every bit of `route_en` and `route_sel` is 0. Both stay 0 until the first update strobe.
- R2: Reset does not alter the holding rank. An update issued after reset drives the outputs with the pattern that was staged before reset.
- R3: In parallel mode (`load_mode`=0), a strobe with `pw_bcast`=0 writes `{pw_en, pw_src}` into the holding entry of output `pw_dst` only. Every other entry keeps its value.
- R4: In parallel mode, a strobe with `pw_bcast`=1 writes `{pw_en, pw_src}` into the holding entry of every output, whatever the value of `pw_dst`.
- R5: An update strobe sampled at a clock edge makes every output show its holding entry from the next cycle on. Each output's enable is entry bit 5 and its select is entry bits 4..0, and all outputs change together.
- R6: When an update and a parallel write are sampled at the same edge, the outputs take the holding contents from before that write. The write still lands in the holding rank.
- R7: In serial mode (`load_mode`=1), each rising edge of `ser_clk` shifts `ser_din` into the 192-bit holding chain. The first bit shifted in after 192 edges is the enable of output 31. The order runs from output 31 down to output 0, and each entry goes enable first and then select bits 4 down to 0. Holding `ser_clk` high causes one shift only.
- R8: On each serial shift, `ser_dout` takes the bit that leaves the top of the chain. Reset sets `ser_dout` to 0.
- R9: Parallel strobes have no effect in serial mode, and `ser_clk` edges have no effect in parallel mode, on either the holding rank or `ser_dout`.
- R10: Without an update strobe, `route_en` and `route_sel` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the live rank |
| load_mode | input | 1 | 0 = parallel loading, 1 = serial loading |
| pw_stb | input | 1 | Parallel write strobe |
| pw_bcast | input | 1 | Broadcast write: all entries, address ignored |
| pw_dst | input | 5 | Output address for a parallel write |
| pw_src | input | 5 | Input index to store |
| pw_en | input | 1 | Enable bit to store |
| ser_clk | input | 1 | Serial shift clock, sampled on `clk` |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Bit shifted out of the chain, for daisy chaining |
| upd | input | 1 | Global update strobe |
| route_sel | output | 160 | Per-output input index, output k at bits 5k+4..5k |
| route_en | output | 32 | Per-output enable |

## Verification
The assertions take for granted that `ser_clk` is a level sampled by `clk` and changes no faster than once per clock, and that reset is held for at least one full clock. The holding-rank checks also take for granted that the holding rank has been written by a broadcast before serial mode is entered, so it never holds unknown bits. The stimulus keeps within these limits. It drives every input half a period away from the sampling edge, holds `ser_clk` high and then low for a whole cycle each, issues a broadcast before any serial traffic, and draws random addresses, indices and serial bits from a fixed seed.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    localparam int DEF_OUTS = 32;
    localparam int DEF_INS  = 32;

    typedef enum logic {
        LOAD_PAR = 1'b0,
        LOAD_SER = 1'b1
    } load_mode_e;

    // entry layout: enable in the top bit, input index below it
    function automatic int entry_width(input int n_ins);
        return $clog2(n_ins) + 1;
    endfunction

endpackage

// File: rtl/xpt_edge_det.sv
module xpt_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/xpt_stage_rank.sv
module xpt_stage_rank #(
    parameter  int N_OUT   = 32,
    parameter  int ENT_W   = 6,
    parameter  int OAW     = 5,
    localparam int CHAIN_W = N_OUT * ENT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               par_wr,
    input  logic               bcast,
    input  logic [OAW-1:0]     waddr,
    input  logic [ENT_W-1:0]   wdata,
    input  logic               shift_en,
    input  logic               sdin,
    output logic [CHAIN_W-1:0] q,
    output logic               sdout
);
    logic [CHAIN_W-1:0] shifted;

    assign shifted = {q[CHAIN_W-2:0], sdin};

    for (genvar k = 0; k < N_OUT; k++) begin : g_ent
        logic [ENT_W-1:0] ent;
        logic             hit;

        assign hit = par_wr && (bcast || (waddr == OAW'(k)));

        always_ff @(posedge clk) begin
            if (!rst) begin
                if (shift_en)
                    ent <= shifted[k*ENT_W +: ENT_W];
                else if (hit)
                    ent <= wdata;
            end
        end

        assign q[k*ENT_W +: ENT_W] = ent;
    end

    always_ff @(posedge clk) begin
        if (rst)           sdout <= 1'b0;
        else if (shift_en) sdout <= q[CHAIN_W-1];
    end
endmodule

// File: rtl/xpt_live_rank.sv
module xpt_live_rank #(
    parameter int WIDTH = 192
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (upd) q <= d;
    end
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
    import xpt_pkg::*;
#(
    parameter  int N_OUT   = DEF_OUTS,
    parameter  int N_IN    = DEF_INS,
    localparam int SEL_W   = $clog2(N_IN),
    localparam int OAW     = $clog2(N_OUT),
    localparam int ENT_W   = SEL_W + 1,
    localparam int CHAIN_W = N_OUT * ENT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_mode,
    input  logic                   pw_stb,
    input  logic                   pw_bcast,
    input  logic [OAW-1:0]         pw_dst,
    input  logic [SEL_W-1:0]       pw_src,
    input  logic                   pw_en,
    input  logic                   ser_clk,
    input  logic                   ser_din,
    output logic                   ser_dout,
    input  logic                   upd,
    output logic [N_OUT*SEL_W-1:0] route_sel,
    output logic [N_OUT-1:0]       route_en
);
    load_mode_e         mode;
    logic               ser_rise;
    logic               sh_pulse;
    logic               par_wr;
    logic [CHAIN_W-1:0] stage_q;
    logic [CHAIN_W-1:0] live_q;

    assign mode = load_mode_e'(load_mode);

    xpt_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ser_clk),
        .rise (ser_rise)
    );

    assign sh_pulse = ser_rise && (mode == LOAD_SER);
    assign par_wr   = pw_stb   && (mode == LOAD_PAR);

    xpt_stage_rank #(
        .N_OUT (N_OUT),
        .ENT_W (ENT_W),
        .OAW   (OAW)
    ) u_stage (
        .clk      (clk),
        .rst      (rst),
        .par_wr   (par_wr),
        .bcast    (pw_bcast),
        .waddr    (pw_dst),
        .wdata    ({pw_en, pw_src}),
        .shift_en (sh_pulse),
        .sdin     (ser_din),
        .q        (stage_q),
        .sdout    (ser_dout)
    );

    xpt_live_rank #(
        .WIDTH (CHAIN_W)
    ) u_live (
        .clk (clk),
        .rst (rst),
        .upd (upd),
        .d   (stage_q),
        .q   (live_q)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        assign route_en[k]                 = live_q[k*ENT_W + SEL_W];
        assign route_sel[k*SEL_W +: SEL_W] = live_q[k*ENT_W +: SEL_W];
    end
endmodule

// File: rtl/xpt_cfg_ctrl_chk.sv
module xpt_cfg_ctrl_chk #(
    parameter  int N_OUT   = 32,
    parameter  int N_IN    = 32,
    localparam int SEL_W   = $clog2(N_IN),
    localparam int ENT_W   = SEL_W + 1,
    localparam int CHAIN_W = N_OUT * ENT_W
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   load_mode,
    input logic                   pw_stb,
    input logic                   pw_bcast,
    input logic [SEL_W-1:0]       pw_src,
    input logic                   pw_en,
    input logic                   upd,
    input logic                   shift_pulse,
    input logic [CHAIN_W-1:0]     stage_q,
    input logic                   ser_dout,
    input logic [N_OUT*SEL_W-1:0] route_sel,
    input logic [N_OUT-1:0]       route_en
);
    logic [N_OUT-1:0]       st_en;
    logic [N_OUT*SEL_W-1:0] st_sel;

    for (genvar k = 0; k < N_OUT; k++) begin : g_split
        assign st_en[k]                 = stage_q[k*ENT_W + SEL_W];
        assign st_sel[k*SEL_W +: SEL_W] = stage_q[k*ENT_W +: SEL_W];
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (route_en == '0 && route_sel == '0));

    // R5
    upd_copy_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> (route_en == $past(st_en) && route_sel == $past(st_sel)));

    // R10
    live_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(route_en) && $stable(route_sel)));

    // R8
    sdout_chk: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> (ser_dout == $past(stage_q[CHAIN_W-1])));

    // R9
    ser_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (load_mode && !shift_pulse) |=> $stable(stage_q));

    // R4
    bcast_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_mode && pw_stb && pw_bcast) |=>
            (stage_q == {N_OUT{$past({pw_en, pw_src})}}));
endmodule

bind xpt_cfg_ctrl xpt_cfg_ctrl_chk #(
    .N_OUT (N_OUT),
    .N_IN  (N_IN)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .load_mode   (load_mode),
    .pw_stb      (pw_stb),
    .pw_bcast    (pw_bcast),
    .pw_src      (pw_src),
    .pw_en       (pw_en),
    .upd         (upd),
    .shift_pulse (sh_pulse),
    .stage_q     (stage_q),
    .ser_dout    (ser_dout),
    .route_sel   (route_sel),
    .route_en    (route_en)
);

// File: tb/xpt_cfg_ctrl_test.sv
module xpt_cfg_ctrl_test;
    localparam int NO = 32;
    localparam int SW = 5;
    localparam int EW = 6;
    localparam int CW = NO * EW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_mode = 1'b0;
    logic pw_stb = 1'b0, pw_bcast = 1'b0, pw_en = 1'b0;
    logic [4:0] pw_dst = '0, pw_src = '0;
    logic ser_clk = 1'b0, ser_din = 1'b0, upd = 1'b0;
    logic ser_dout;
    logic [NO*SW-1:0] route_sel;
    logic [NO-1:0] route_en;

    int checks = 0;
    int fails = 0;

    logic [CW-1:0] m1 = '0;
    logic [CW-1:0] m2 = '0;
    logic m_dout = 1'b0;
    logic [CW-1:0] saved;

    always #4 clk = ~clk;

    xpt_cfg_ctrl uut (
        .clk(clk), .rst(rst), .load_mode(load_mode),
        .pw_stb(pw_stb), .pw_bcast(pw_bcast), .pw_dst(pw_dst),
        .pw_src(pw_src), .pw_en(pw_en), .ser_clk(ser_clk),
        .ser_din(ser_din), .ser_dout(ser_dout), .upd(upd),
        .route_sel(route_sel), .route_en(route_en)
    );

    function automatic logic [NO-1:0] exp_en(input logic [CW-1:0] v);
        logic [NO-1:0] r;
        for (int k = 0; k < NO; k++) r[k] = v[k*EW + 5];
        return r;
    endfunction

    function automatic logic [NO*SW-1:0] exp_sel(input logic [CW-1:0] v);
        logic [NO*SW-1:0] r;
        for (int k = 0; k < NO; k++) r[k*SW +: SW] = v[k*EW +: SW];
        return r;
    endfunction

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_out(input string req);
        checks++;
        if (route_en !== exp_en(m2)) begin
            fails++;
            $display("FAIL %s route_en actual=%h expected=%h", req, route_en, exp_en(m2));
        end
        checks++;
        if (route_sel !== exp_sel(m2)) begin
            fails++;
            $display("FAIL %s route_sel actual=%h expected=%h", req, route_sel, exp_sel(m2));
        end
    endtask

    task automatic check_dout(input string req);
        checks++;
        if (ser_dout !== m_dout) begin
            fails++;
            $display("FAIL %s ser_dout actual=%b expected=%b", req, ser_dout, m_dout);
        end
    endtask

    task automatic pwrite(input logic [4:0] o, input logic [4:0] i,
                          input logic e, input logic b);
        pw_dst = o; pw_src = i; pw_en = e; pw_bcast = b; pw_stb = 1'b1;
        tick();
        pw_stb = 1'b0; pw_bcast = 1'b0;
        if (!load_mode) begin
            for (int k = 0; k < NO; k++)
                if (b || k == int'(o)) m1[k*EW +: EW] = {e, i};
        end
    endtask

    task automatic do_upd;
        upd = 1'b1;
        tick();
        upd = 1'b0;
        m2 = m1;
    endtask

    task automatic do_rst;
        rst = 1'b1;
        tick();
        rst = 1'b0;
        m2 = '0;
        m_dout = 1'b0;
    endtask

    task automatic sshift(input logic b);
        ser_din = b; ser_clk = 1'b1;
        tick();
        ser_clk = 1'b0;
        if (load_mode) begin
            m_dout = m1[CW-1];
            m1 = {m1[CW-2:0], b};
        end
        tick();
    endtask

    initial begin
        void'($urandom(32'd4817));
        @(negedge clk);
        tick();
        rst = 1'b0;
        // R1: reset state
        check_out("R1");
        check_dout("R8 reset");

        // R3 / R10: random single writes, outputs hold until update
        pwrite(5'd0, 5'd0, 1'b0, 1'b1);
        for (int n = 0; n < 24; n++)
            pwrite(5'($urandom), 5'($urandom), 1'($urandom), 1'b0);
        check_out("R10 before update");
        do_upd();
        check_out("R3/R5 after update");
        // directed: top and bottom addresses
        pwrite(5'd31, 5'd17, 1'b1, 1'b0);
        pwrite(5'd0, 5'd31, 1'b1, 1'b0);
        check_out("R10 hold");
        do_upd();
        check_out("R3 edge addresses");

        // R4: broadcast ignores the address
        pwrite(5'd9, 5'd22, 1'b1, 1'b1);
        do_upd();
        check_out("R4 broadcast");
        pwrite(5'd3, 5'd0, 1'b0, 1'b1);
        do_upd();
        check_out("R4 broadcast clear");

        // R6: update and write in the same cycle
        for (int n = 0; n < 6; n++)
            pwrite(5'($urandom), 5'($urandom), 1'b1, 1'b0);
        pw_dst = 5'd12; pw_src = 5'd25; pw_en = 1'b1; pw_stb = 1'b1; upd = 1'b1;
        tick();
        pw_stb = 1'b0; upd = 1'b0;
        m2 = m1;
        m1[12*EW +: EW] = {1'b1, 5'd25};
        check_out("R6 same cycle old data");
        do_upd();
        check_out("R6 write landed");

        // R2: reset leaves staged data
        saved = m1;
        do_rst();
        check_out("R1 after reset");
        do_upd();
        checks++;
        if (m2 !== saved) begin
            fails++;
            $display("FAIL R2 model actual=%h expected=%h", m2, saved);
        end
        check_out("R2 staged survives reset");

        // R9: parallel strobes ignored in serial mode
        load_mode = 1'b1;
        tick();
        pwrite(5'd4, 5'd9, 1'b1, 1'b1);
        pwrite(5'd7, 5'd3, 1'b0, 1'b0);
        do_upd();
        check_out("R9 parallel ignored in serial");

        // R7 / R8: full serial load, dout replays old chain
        for (int n = 0; n < CW; n++) begin
            sshift(1'($urandom));
            check_dout("R8 shift out");
        end
        do_upd();
        check_out("R7 serial load");
        // directed: output 31 gets en=1 sel=3, rest off
        for (int n = 0; n < CW; n++)
            sshift((n == 0 || n == 4 || n == 5) ? 1'b1 : 1'b0);
        do_upd();
        check_out("R7 ordering");
        checks++;
        if (route_en !== 32'h8000_0000 || route_sel[31*SW +: SW] !== 5'd3) begin
            fails++;
            $display("FAIL R7 out31 actual=%h/%h expected=80000000/03",
                     route_en, route_sel[31*SW +: SW]);
        end
        // R7: ser_clk held high shifts once
        ser_din = 1'b1; ser_clk = 1'b1;
        for (int n = 0; n < 5; n++) tick();
        ser_clk = 1'b0;
        m_dout = m1[CW-1];
        m1 = {m1[CW-2:0], 1'b1};
        tick();
        check_dout("R7 held high");
        do_upd();
        check_out("R7 single shift");

        // R9: serial edges ignored in parallel mode
        load_mode = 1'b0;
        tick();
        for (int n = 0; n < 10; n++) sshift(1'($urandom));
        check_dout("R9 dout unchanged in parallel");
        do_upd();
        check_out("R9 serial ignored in parallel");

        // R10: random mix of writes with no update
        for (int n = 0; n < 40; n++) begin
            pwrite(5'($urandom), 5'($urandom), 1'($urandom), 1'($urandom % 8 == 0));
            check_out("R10 no update");
        end
        do_upd();
        check_out("R5 final update");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule